// File: doc/BRIEF.md
# Atomic Read-Modify-Write Sequencer

This block carries out one atomic read-modify-write operation on a bus that supports exclusive accesses but does not allow them to overlap. A request brings in a word address, a register operand and an operation code. The block issues an exclusive read and combines the returned memory word with the operand in a small ALU. It then issues an exclusive write of the result to the same address. Every access has one address-phase cycle followed by one data-phase cycle. One attempt therefore takes four bus cycles.

The bus may report a lost reservation on the write. In that case the block starts the read and write pair again with the same latched operands, and it computes a new result from the new read. It keeps doing this until the write succeeds. If the read is refused a reservation, the block stops and reports an access fault, so it can never loop forever. A request whose address is not word-aligned is rejected at once, with no bus traffic. Every operation ends with a single-cycle completion pulse. When the write succeeds, the output returns the memory word read by the successful attempt, for the destination register.

Top module: `amo_seq`

## Requirements
- R1: With `start` high in an idle cycle and `req_addr[1:0]` not zero, the next cycle shows `done`=1, `fault_misalign`=1 and `fault_access`=0. No `bus_req` is raised for that operation.
- R2: An aligned request sampled at clock edge E makes the next cycle a read address phase: `bus_req`=1, `bus_write`=0, `bus_excl`=1, and `bus_addr` equal to the request address.
- R3: If `bus_exokay` is low in the read data phase, the following cycle shows `done`=1, `fault_access`=1 and `fault_misalign`=0. No write is issued.
- R4: If `bus_exokay` is high in the read data phase, the following cycle is a write address phase: `bus_req`=1, `bus_write`=1, `bus_excl`=1, and the same `bus_addr`.
- R5: In the write data phase, `bus_wdata` is f(M, X), where M is the word read in that attempt and X is the latched operand. The op codes are: 0 swap (X), 1 add (M+X modulo 2^32), 2 xor, 3 and, 4 or, 5 signed min, 6 signed max, 7 unsigned min, 8 unsigned max. Codes 9 to 15 act as swap.
- R6: If `bus_exokay` is low in the write data phase, the next cycle is a new read address phase. Each attempt costs exactly four cycles.
- R7: If `bus_exokay` is high in the write data phase, the next cycle shows `done`=1 with both faults 0, and `rd_value` equal to the word read by that attempt.
- R8: Address, operand and op code are latched when the request is accepted. Changes on `req_*` while `busy` is high have no effect, and neither does `start` while `busy` is high.
- R9: `done` lasts exactly one cycle. At most one fault flag is high, and only while `done` is high. After reset, `done`, `busy` and `bus_req` are 0.
- R10: `bus_req` is never high in two consecutive cycles, so no two accesses overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, accepted only when idle |
| req_addr | input | ADDR_W | Target byte address |
| req_operand | input | DATA_W | Register operand |
| req_op | input | 4 | Operation code |
| busy | output | 1 | Operation in progress |
| bus_req | output | 1 | Address-phase valid |
| bus_write | output | 1 | 1 for write, 0 for read |
| bus_excl | output | 1 | Exclusive access marker |
| bus_addr | output | ADDR_W | Access address |
| bus_wdata | output | DATA_W | Write data, valid in the write data phase |
| bus_rdata | input | DATA_W | Read data, valid in the read data phase |
| bus_exokay | input | 1 | Exclusive success status in the data phase |
| done | output | 1 | One-cycle completion pulse |
| fault_access | output | 1 | Read reservation refused (with done) |
| fault_misalign | output | 1 | Misaligned address rejected (with done) |
| rd_value | output | DATA_W | Original memory word for the destination register |

## Verification
The bench sweeps all nine op codes, plus one unused code, against operand pairs chosen around the sign boundary. A design that compared signed values as unsigned would return the wrong min or max when the sign bits differ. The bench also forces lost reservations, and on each retry it changes the memory word. A design that reused a stale result, or returned the first read instead of the last, would write or report the wrong word. It checks that a refused read and a misaligned address each end with no write and the right fault. During the operation it scrambles the request inputs and pulses `start`, which catches a design that re-latches its operands mid-operation.

// File: rtl/amo_pkg.sv
package amo_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    AMO_SWAP = 4'd0,
    AMO_ADD  = 4'd1,
    AMO_XOR  = 4'd2,
    AMO_AND  = 4'd3,
    AMO_OR   = 4'd4,
    AMO_MIN  = 4'd5,
    AMO_MAX  = 4'd6,
    AMO_MINU = 4'd7,
    AMO_MAXU = 4'd8
  } amo_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_ADDR,
    S_RD_DATA,
    S_WR_ADDR,
    S_WR_DATA,
    S_FIN
  } seq_state_e;
endpackage

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] mem_word,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] result
);
  localparam int MSB = DATA_W - 1;

  // signed less-than built from the sign bits and an unsigned compare
  function automatic logic lt_signed(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    if (a[MSB] != b[MSB]) return a[MSB];
    return a < b;
  endfunction

  function automatic logic [DATA_W-1:0] combine(input logic [OP_W-1:0] code,
                                               input logic [DATA_W-1:0] m,
                                               input logic [DATA_W-1:0] x);
    case (amo_op_e'(code))
      AMO_ADD:  return m + x;
      AMO_XOR:  return m ^ x;
      AMO_AND:  return m & x;
      AMO_OR:   return m | x;
      AMO_MIN:  return lt_signed(m, x) ? m : x;
      AMO_MAX:  return lt_signed(m, x) ? x : m;
      AMO_MINU: return (m < x) ? m : x;
      AMO_MAXU: return (m < x) ? x : m;
      default:  return x;  // swap and unused codes
    endcase
  endfunction

  assign result = combine(op, mem_word, operand);
endmodule

// File: rtl/amo_ctrl.sv
module amo_ctrl
  import amo_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic misaligned,
  input  logic exokay,
  output logic busy,
  output logic rd_addr_ph,
  output logic rd_data_ph,
  output logic wr_addr_ph,
  output logic wr_data_ph,
  output logic fin,
  output logic ev_accept,
  output logic ev_rd_ok,
  output logic ev_rd_refused,
  output logic ev_wr_ok,
  output logic ev_wr_lost
);
  seq_state_e state_q, state_d;

  assign busy       = (state_q != S_IDLE);
  assign rd_addr_ph = (state_q == S_RD_ADDR);
  assign rd_data_ph = (state_q == S_RD_DATA);
  assign wr_addr_ph = (state_q == S_WR_ADDR);
  assign wr_data_ph = (state_q == S_WR_DATA);
  assign fin        = (state_q == S_FIN);

  // named events for datapath and assertions
  assign ev_accept     = (state_q == S_IDLE) && start;
  assign ev_rd_ok      = rd_data_ph && exokay;
  assign ev_rd_refused = rd_data_ph && !exokay;
  assign ev_wr_ok      = wr_data_ph && exokay;
  assign ev_wr_lost    = wr_data_ph && !exokay;

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:    if (start) state_d = misaligned ? S_FIN : S_RD_ADDR;
      S_RD_ADDR: state_d = S_RD_DATA;
      S_RD_DATA: state_d = exokay ? S_WR_ADDR : S_FIN;
      S_WR_ADDR: state_d = S_WR_DATA;
      S_WR_DATA: state_d = exokay ? S_FIN : S_RD_ADDR;
      S_FIN:     state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  // R10: an address phase is always followed by a cycle without one
  p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_ph || wr_addr_ph) |=> !(rd_addr_ph || wr_addr_ph));

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin);

  // R6: a lost write reservation leads straight into a new read
  p_retry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_lost |=> rd_addr_ph);

  // R3: a refused read never reaches a write
  p_refuse_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd_refused |=> fin);
endmodule

// File: rtl/amo_seq.sv
module amo_seq
  import amo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_operand,
  input  logic [OP_W-1:0]   req_op,
  output logic              busy,
  output logic              bus_req,
  output logic              bus_write,
  output logic              bus_excl,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_exokay,
  output logic              done,
  output logic              fault_access,
  output logic              fault_misalign,
  output logic [DATA_W-1:0] rd_value
);
  localparam int ALIGN_W = $clog2(DATA_W / 8);

  logic rd_addr_ph, rd_data_ph, wr_addr_ph, wr_data_ph, fin;
  logic ev_accept, ev_rd_ok, ev_rd_refused, ev_wr_ok, ev_wr_lost;
  logic misaligned;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] opnd_q, old_q, new_q, alu_out;
  logic [OP_W-1:0]   op_q;
  logic              flt_acc_q, flt_mis_q;

  assign misaligned = (req_addr[ALIGN_W-1:0] != '0);

  amo_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .misaligned    (misaligned),
    .exokay        (bus_exokay),
    .busy          (busy),
    .rd_addr_ph    (rd_addr_ph),
    .rd_data_ph    (rd_data_ph),
    .wr_addr_ph    (wr_addr_ph),
    .wr_data_ph    (wr_data_ph),
    .fin           (fin),
    .ev_accept     (ev_accept),
    .ev_rd_ok      (ev_rd_ok),
    .ev_rd_refused (ev_rd_refused),
    .ev_wr_ok      (ev_wr_ok),
    .ev_wr_lost    (ev_wr_lost)
  );

  amo_alu #(.DATA_W(DATA_W)) u_alu (
    .op       (op_q),
    .mem_word (bus_rdata),
    .operand  (opnd_q),
    .result   (alu_out)
  );

  // request latch: loaded only on acceptance, held across retries
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      opnd_q    <= '0;
      op_q      <= '0;
      flt_mis_q <= 1'b0;
    end else if (ev_accept) begin
      addr_q    <= req_addr;
      opnd_q    <= req_operand;
      op_q      <= req_op;
      flt_mis_q <= misaligned;
    end
  end

  // read capture: old word and recomputed write value for every attempt
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      old_q <= '0;
      new_q <= '0;
    end else if (ev_rd_ok) begin
      old_q <= bus_rdata;
      new_q <= alu_out;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             flt_acc_q <= 1'b0;
    else if (ev_accept)     flt_acc_q <= 1'b0;
    else if (ev_rd_refused) flt_acc_q <= 1'b1;
  end

  assign bus_req        = rd_addr_ph || wr_addr_ph;
  assign bus_write      = wr_addr_ph;
  assign bus_excl       = bus_req;
  assign bus_addr       = addr_q;
  assign bus_wdata      = new_q;
  assign done           = fin;
  assign fault_access   = fin && flt_acc_q;
  assign fault_misalign = fin && flt_mis_q;
  assign rd_value       = old_q;

  // R1: a misaligned rejection is preceded by no bus request
  p_misalign_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fault_misalign |-> !$past(bus_req));

  // R4: every write address phase comes two cycles after a read address phase
  p_write_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_write) |-> $past(bus_req && !bus_write, 2));

  // R8: latched request is stable while the operation runs
  p_request_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(addr_q) && $stable(opnd_q) && $stable(op_q)));

  // R9: faults appear only with done, and never both
  p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_access || fault_misalign) |-> (done && !(fault_access && fault_misalign)));

  // R7: success is signalled the cycle after an accepted write
  p_success_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_ok |=> (done && !fault_access && !fault_misalign));
endmodule

// File: tb/amo_seq_tb.sv
`timescale 1ns/1ps
module amo_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_operand = '0;
  logic [3:0]  req_op = '0;
  logic        busy, bus_req, bus_write, bus_excl;
  logic [31:0] bus_addr, bus_wdata;
  logic [31:0] bus_rdata = 32'hdead_beef;
  logic        bus_exokay = 1'b0;
  logic        done, fault_access, fault_misalign;
  logic [31:0] rd_value;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  amo_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_addr(req_addr),
    .req_operand(req_operand), .req_op(req_op), .busy(busy),
    .bus_req(bus_req), .bus_write(bus_write), .bus_excl(bus_excl),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_exokay(bus_exokay), .done(done), .fault_access(fault_access),
    .fault_misalign(fault_misalign), .rd_value(rd_value)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] m, input logic [31:0] x);
    case (op)
      4'd1: return m + x;
      4'd2: return m ^ x;
      4'd3: return m & x;
      4'd4: return m | x;
      4'd5: return ($signed(m) < $signed(x)) ? m : x;
      4'd6: return ($signed(m) > $signed(x)) ? m : x;
      4'd7: return (m < x) ? m : x;
      4'd8: return (m > x) ? m : x;
      default: return x;
    endcase
  endfunction

  task automatic run_op(input logic [31:0] addr, input logic [31:0] opnd, input logic [3:0] op,
                        input logic [31:0] mem0, input bit refuse, input int n_lost);
    logic [31:0] mem;
    mem = mem0;
    @(negedge clk);
    start = 1'b1; req_addr = addr; req_operand = opnd; req_op = op;
    @(negedge clk);
    // R8: scramble request and pulse start during the operation
    req_addr = ~addr; req_operand = ~opnd; req_op = op ^ 4'h3;
    if (addr[1:0] != 2'b00) begin
      start = 1'b0;
      chk(done && fault_misalign && !fault_access && !bus_req, "R1 misaligned reject",
          {28'd0, done, fault_misalign, fault_access, bus_req}, 32'hc);
      @(negedge clk);
      chk(!done && !busy, "R9 misalign pulse ends", {30'd0, done, busy}, 32'h0);
      return;
    end
    for (int a = 0; a <= n_lost; a++) begin
      mem = mem0 + 32'(a * 17);
      chk(bus_req && !bus_write && bus_excl && bus_addr == addr,
          (a == 0) ? "R2 read address phase" : "R6 retry read address phase", bus_addr, addr);
      bus_rdata = mem; bus_exokay = !refuse;
      @(negedge clk);
      start = 1'b0;
      chk(!bus_req && !done, "R10 read data phase idle bus", {31'd0, bus_req}, 32'h0);
      if (refuse) begin
        @(negedge clk);
        bus_exokay = 1'b0; bus_rdata = 32'hdead_beef;
        chk(done && fault_access && !fault_misalign && !bus_req, "R3 refused read fault",
            {28'd0, done, fault_access, fault_misalign, bus_req}, 32'hc);
        @(negedge clk);
        chk(!done && !busy, "R9 fault pulse ends", {30'd0, done, busy}, 32'h0);
        return;
      end
      @(negedge clk);
      bus_rdata = 32'hdead_beef; bus_exokay = 1'b0;
      chk(bus_req && bus_write && bus_excl && bus_addr == addr, "R4 write address phase", bus_addr, addr);
      bus_exokay = (a == n_lost);
      @(negedge clk);
      chk(bus_wdata == model(op, mem, opnd), "R5 write value", bus_wdata, model(op, mem, opnd));
      chk(!bus_req, "R10 write data phase idle bus", {31'd0, bus_req}, 32'h0);
      @(negedge clk);
      bus_exokay = 1'b0;
    end
    chk(done && !fault_access && !fault_misalign, "R7 success done",
        {29'd0, done, fault_access, fault_misalign}, 32'h4);
    chk(rd_value == mem, "R7 old value", rd_value, mem);
    @(negedge clk);
    chk(!done && !busy, "R9 done pulse ends", {30'd0, done, busy}, 32'h0);
  endtask

  logic [31:0] vals [6];

  initial begin
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'hffff_ffff;
    vals[3] = 32'h7fff_ffff; vals[4] = 32'h8000_0000; vals[5] = 32'h1234_5678;
    repeat (3) @(negedge clk);
    chk(!done && !busy && !bus_req, "R9 reset state", {29'd0, done, busy, bus_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !busy && !bus_req, "R9 idle after reset", {29'd0, done, busy, bus_req}, 32'h0);
    // R5 sweep: every op against sign-boundary pairs
    for (int op = 0; op < 9; op++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          run_op(32'h0000_1000 + 32'(4 * i), vals[j], 4'(op), vals[i], 1'b0, 0);
    // R5 unused code acts as swap
    run_op(32'h0000_2000, 32'h5555_aaaa, 4'hc, 32'h0f0f_0f0f, 1'b0, 0);
    // R6 retries with changing memory
    for (int n = 1; n <= 3; n++)
      run_op(32'h0000_3000, 32'h0000_0010, 4'd1, 32'h0000_0100 * 32'(n), 1'b0, n);
    run_op(32'h0000_3004, 32'h8000_0000, 4'd5, 32'h7fff_fff0, 1'b0, 2);
    // R3 refused read
    run_op(32'h0000_4000, 32'h1, 4'd0, 32'h2, 1'b1, 0);
    // R1 misaligned offsets
    for (int k = 1; k < 4; k++)
      run_op(32'h0000_5000 + 32'(k), 32'h1, 4'd1, 32'h0, 1'b0, 0);
    // R8 after faults, a normal op still uses fresh latched values
    run_op(32'h0000_6000, 32'h0000_00ff, 4'd3, 32'h0000_0f0f, 1'b0, 1);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule